// File: doc/BRIEF.md
# Codec Link Power Timing Controller

This block produces the timing for the power-management signalling of an audio codec serial link. It runs entirely on the host bus clock. A free-running prescaler divides that clock into a periodic tick, nominally every 250 ns. Both timed operations count these ticks.

The first operation is a cold reset. When software asks for one, the active-low codec reset is held low for a programmed number of ticks. The second is a resume request, which forces the link's sync line high for a separate tick count. That count carries one extra tick because the prescaler phase is unknown when the request arrives. Each operation has a busy level and a one-cycle done strobe.

The block also watches the raw bit clock coming back from the codec. It passes that clock through a two-flop synchronizer and raises a suspended flag once no edge has been seen for a set number of host cycles. The defaults suit a 200 MHz host clock: a reload value of 49, 4 reset ticks, 5 resume ticks and 33 idle cycles.

Top module: `codec_pwr_timer`

## Requirements
- R1: While reset is held and right after it is released, codecResetN is 0, resetBusy is 1, syncOverride and resumeBusy are 0, both done strobes are 0 and suspended is 1.
- R2: Counting rising edges from reset release, the first being edge 1, a prescaler tick lands on every edge whose index is a multiple of PRESCALE_RELOAD+1. The reset stretch begun by system reset ends on the RESET_TICKS-th such edge.
- R3: A coldReq sampled high on an edge while resetBusy is 0 drives codecResetN low and resetBusy high from that edge. Both return on the RESET_TICKS-th tick edge after the starting edge.
- R4: resetDone is 1 for exactly the one cycle that follows the edge on which a reset stretch ends.
- R5: A coldReq sampled while resetBusy is 1 is ignored and does not lengthen the running stretch. This includes a request on the edge where the stretch ends.
- R6: A resumeReq sampled high on an edge while resumeBusy is 0 drives syncOverride and resumeBusy high from that edge. Both return on the RESUME_TICKS-th tick edge after the starting edge.
- R7: resumeDone is 1 for exactly the one cycle that follows the edge on which a resume pulse ends.
- R8: A resumeReq sampled while resumeBusy is 1 is ignored and does not lengthen the running pulse.
- R9: Reset stretching and resume signalling are independent. Requests for both on the same edge are both accepted, and each operation keeps its own timing.
- R10: A change of bitClkIn sampled on edge k is seen after the two-flop synchronizer and clears suspended on edge k+2.
- R11: suspended rises on edge k+2+SUSPEND_CYCLES when the last change of bitClkIn was sampled on edge k.
- R12: The idle count saturates. suspended stays 1 for any length of idle time, and one later change clears it again as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| coldReq | input | 1 | Request a cold reset of the codec |
| resumeReq | input | 1 | Request resume signalling on sync |
| bitClkIn | input | 1 | Raw bit clock from the codec, asynchronous |
| codecResetN | output | 1 | Active-low reset to the codec |
| syncOverride | output | 1 | Forces the sync line high while 1 |
| suspended | output | 1 | Bit clock is considered stopped |
| resetBusy | output | 1 | A reset stretch is running |
| resetDone | output | 1 | One-cycle strobe at the end of a reset stretch |
| resumeBusy | output | 1 | A resume pulse is running |
| resumeDone | output | 1 | One-cycle strobe at the end of a resume pulse |

## Verification
The reset stretch and the resume pulse share the prescaler tick, so both can start on one edge or end on the same tick edge. A directed phase drives coldReq and resumeReq together on a single edge. Random stimulus lets start and end edges of the two operations collide at arbitrary prescaler phases. Each output is compared every cycle against a bench model that tracks the prescaler phase and both operations separately. A request landing on the very edge where its own operation ends is judged the same way; it must be dropped.

// File: rtl/pwr_timer_pkg.sv
package pwr_timer_pkg;

  // Strobes from the control FSM to the datapath counters
  typedef struct packed {
    logic rstStart;  // clear the reset tick counter
    logic rstRun;    // reset stretch in progress
    logic resStart;  // clear the resume tick counter
    logic resRun;    // resume pulse in progress
  } ctrlStrobes_t;

endpackage

// File: rtl/pwr_op_counter.sv
module pwr_op_counter #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic start,
  input  logic run,
  output logic last
);
  localparam int CNT_W = $clog2(TICKS + 1);

  logic [CNT_W-1:0] tickCnt;

  assign last = run && tick && (tickCnt == CNT_W'(TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (start) begin
      tickCnt <= '0;
    end else if (run && tick && !last) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < CNT_W'(TICKS)) else $error("tick counter out of range"); // R3

endmodule

// File: rtl/pwr_timer_datapath.sv
module pwr_timer_datapath
  import pwr_timer_pkg::*;
#(
  parameter int PRESCALE_RELOAD = 49,
  parameter int RESET_TICKS     = 4,
  parameter int RESUME_TICKS    = 5,
  parameter int SUSPEND_CYCLES  = 33
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         bitClkIn,
  output logic         rstLast,
  output logic         resLast,
  output logic         suspended
);
  localparam int PS_W   = (PRESCALE_RELOAD > 0) ? $clog2(PRESCALE_RELOAD + 1) : 1;
  localparam int IDLE_W = $clog2(SUSPEND_CYCLES + 1);
  localparam int SYNC_STAGES = 3;

  // Prescaler: reload, count down, tick at zero
  logic [PS_W-1:0] psCnt;
  logic            tick;

  assign tick = (psCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= PS_W'(PRESCALE_RELOAD);
    end else if (tick) begin
      psCnt <= PS_W'(PRESCALE_RELOAD);
    end else begin
      psCnt <= psCnt - 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (PRESCALE_RELOAD > 0 && tick) |=> !tick) else $error("back-to-back ticks"); // R2

  // One tick counter per timed operation
  logic [1:0] opStart, opRun, opLast;
  assign opStart = {strobes.resStart, strobes.rstStart};
  assign opRun   = {strobes.resRun,   strobes.rstRun};

  generate
    for (genvar g = 0; g < 2; g++) begin : gOp
      localparam int OP_TICKS = (g == 0) ? RESET_TICKS : RESUME_TICKS;
      pwr_op_counter #(.TICKS(OP_TICKS)) u_cnt (
        .clk   (clk),
        .rstN  (rstN),
        .tick  (tick),
        .start (opStart[g]),
        .run   (opRun[g]),
        .last  (opLast[g])
      );
    end
  endgenerate

  assign rstLast = opLast[0];
  assign resLast = opLast[1];

  // Bit-clock synchronizer, edge detect and idle counter
  logic [SYNC_STAGES-1:0] bitSync;
  logic                   bitEdge;
  logic [IDLE_W-1:0]      idleCnt;

  assign bitEdge = bitSync[SYNC_STAGES-1] ^ bitSync[SYNC_STAGES-2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitSync <= '0;
      idleCnt <= IDLE_W'(SUSPEND_CYCLES);
    end else begin
      bitSync <= {bitSync[SYNC_STAGES-2:0], bitClkIn};
      if (bitEdge) begin
        idleCnt <= '0;
      end else if (idleCnt != IDLE_W'(SUSPEND_CYCLES)) begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  assign suspended = (idleCnt == IDLE_W'(SUSPEND_CYCLES));

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    bitEdge |=> !suspended) else $error("edge did not clear suspended"); // R10
  AST_IDLE_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (suspended && !bitEdge) |=> suspended) else $error("idle count wrapped"); // R12

endmodule

// File: rtl/pwr_timer_ctrl.sv
module pwr_timer_ctrl
  import pwr_timer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         coldReq,
  input  logic         resumeReq,
  input  logic         rstLast,
  input  logic         resLast,
  output ctrlStrobes_t strobes,
  output logic         resetBusy,
  output logic         resetDone,
  output logic         resumeBusy,
  output logic         resumeDone
);
  logic rstStartNow, resStartNow;

  assign rstStartNow = !resetBusy && coldReq;
  assign resStartNow = !resumeBusy && resumeReq;

  assign strobes.rstStart = rstStartNow;
  assign strobes.rstRun   = resetBusy;
  assign strobes.resStart = resStartNow;
  assign strobes.resRun   = resumeBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetBusy  <= 1'b1;  // codec held in reset from power-up
      resetDone  <= 1'b0;
      resumeBusy <= 1'b0;
      resumeDone <= 1'b0;
    end else begin
      resetDone  <= 1'b0;
      resumeDone <= 1'b0;
      if (resetBusy && rstLast) begin
        resetBusy <= 1'b0;
        resetDone <= 1'b1;
      end else if (rstStartNow) begin
        resetBusy <= 1'b1;
      end
      if (resumeBusy && resLast) begin
        resumeBusy <= 1'b0;
        resumeDone <= 1'b1;
      end else if (resStartNow) begin
        resumeBusy <= 1'b1;
      end
    end
  end

  AST_RST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resetDone |=> !resetDone) else $error("reset done too long"); // R4
  AST_RST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    resetDone |-> ($past(resetBusy) && !resetBusy)) else $error("reset done without end"); // R4
  AST_RST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (resetBusy && coldReq && !rstLast) |=> resetBusy) else $error("busy reset dropped"); // R5
  AST_RES_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resumeDone |=> !resumeDone) else $error("resume done too long"); // R7
  AST_RES_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (resumeBusy && resumeReq && !resLast) |=> resumeBusy) else $error("busy resume dropped"); // R8

endmodule

// File: rtl/codec_pwr_timer.sv
module codec_pwr_timer
  import pwr_timer_pkg::*;
#(
  parameter int PRESCALE_RELOAD = 49,
  parameter int RESET_TICKS     = 4,
  parameter int RESUME_TICKS    = 5,
  parameter int SUSPEND_CYCLES  = 33
) (
  input  logic clk,
  input  logic rstN,
  input  logic coldReq,
  input  logic resumeReq,
  input  logic bitClkIn,
  output logic codecResetN,
  output logic syncOverride,
  output logic suspended,
  output logic resetBusy,
  output logic resetDone,
  output logic resumeBusy,
  output logic resumeDone
);
  ctrlStrobes_t strobes;
  logic rstLast, resLast;

  pwr_timer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .coldReq    (coldReq),
    .resumeReq  (resumeReq),
    .rstLast    (rstLast),
    .resLast    (resLast),
    .strobes    (strobes),
    .resetBusy  (resetBusy),
    .resetDone  (resetDone),
    .resumeBusy (resumeBusy),
    .resumeDone (resumeDone)
  );

  pwr_timer_datapath #(
    .PRESCALE_RELOAD (PRESCALE_RELOAD),
    .RESET_TICKS     (RESET_TICKS),
    .RESUME_TICKS    (RESUME_TICKS),
    .SUSPEND_CYCLES  (SUSPEND_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .bitClkIn  (bitClkIn),
    .rstLast   (rstLast),
    .resLast   (resLast),
    .suspended (suspended)
  );

  assign codecResetN  = !resetBusy;
  assign syncOverride = resumeBusy;

  AST_SYNC_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOverride) |-> $past(resumeReq)) else $error("sync raised without request"); // R6

endmodule

// File: tb/codec_pwr_timer_bench.sv
module codec_pwr_timer_bench;
  localparam int RELOAD = 9;
  localparam int RT     = 4;
  localparam int ST     = 5;
  localparam int IDLE   = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coldReq = 1'b0, resumeReq = 1'b0, bitClkIn = 1'b0;
  logic codecResetN, syncOverride, suspended;
  logic resetBusy, resetDone, resumeBusy, resumeDone;

  int passCnt = 0, totalCnt = 0;
  int bitMode = 0;   // 0 hold, else half period in cycles
  int bitPhase = 0;
  string tagRst = "R3", tagRes = "R6", tagSus = "R11";

  always #4 clk = ~clk;  // 125 MHz

  codec_pwr_timer #(
    .PRESCALE_RELOAD (RELOAD),
    .RESET_TICKS     (RT),
    .RESUME_TICKS    (ST),
    .SUSPEND_CYCLES  (IDLE)
  ) u_codec_pwr_timer (
    .clk (clk), .rstN (rstN), .coldReq (coldReq), .resumeReq (resumeReq),
    .bitClkIn (bitClkIn), .codecResetN (codecResetN), .syncOverride (syncOverride),
    .suspended (suspended), .resetBusy (resetBusy), .resetDone (resetDone),
    .resumeBusy (resumeBusy), .resumeDone (resumeDone)
  );

  // Reference model built from the requirements
  int  mPs, mRstCnt, mResCnt, mIdle;
  bit  mRstAct, mRstDone, mResAct, mResDone;
  bit  mS1, mS2, mS3;

  function automatic bit tickNow(int ps);
    return ps == 0;
  endfunction

  function automatic bit expSuspended(int idle);
    return idle == IDLE;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPs = RELOAD; mRstAct = 1; mRstCnt = 0; mRstDone = 0;
      mResAct = 0; mResCnt = 0; mResDone = 0;
      mS1 = 0; mS2 = 0; mS3 = 0; mIdle = IDLE;
    end else begin
      bit t, e;
      t = tickNow(mPs);
      e = mS2 ^ mS3;
      mRstDone = 0;
      if (mRstAct && t && mRstCnt == RT - 1) begin mRstAct = 0; mRstDone = 1; end
      else if (mRstAct && t) mRstCnt++;
      else if (!mRstAct && coldReq) begin mRstAct = 1; mRstCnt = 0; end
      mResDone = 0;
      if (mResAct && t && mResCnt == ST - 1) begin mResAct = 0; mResDone = 1; end
      else if (mResAct && t) mResCnt++;
      else if (!mResAct && resumeReq) begin mResAct = 1; mResCnt = 0; end
      mPs = t ? RELOAD : mPs - 1;
      mS3 = mS2; mS2 = mS1; mS1 = bitClkIn;
      if (e) mIdle = 0; else if (mIdle < IDLE) mIdle++;
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
  endtask

  task automatic stepCycle();
    @(negedge clk);
    chk(tagRst, "codecResetN", codecResetN, !mRstAct);
    chk(tagRst, "resetBusy",   resetBusy,   mRstAct);
    chk("R4",   "resetDone",   resetDone,   mRstDone);
    chk(tagRes, "syncOverride", syncOverride, mResAct);
    chk(tagRes, "resumeBusy",  resumeBusy,  mResAct);
    chk("R7",   "resumeDone",  resumeDone,  mResDone);
    chk(tagSus, "suspended",   suspended,   expSuspended(mIdle));
    coldReq = 1'b0;
    resumeReq = 1'b0;
    if (bitMode > 0) begin
      bitPhase++;
      if (bitPhase >= bitMode) begin bitPhase = 0; bitClkIn = ~bitClkIn; end
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) stepCycle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    totalCnt++;
    $display("FAIL watchdog all requirements: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    // R1: reset state during and right after reset
    tagRst = "R1"; tagRes = "R1"; tagSus = "R1";
    run(3);
    @(negedge clk) rstN = 1'b1;
    run(1);
    // R2: power-up stretch ends on the RT-th tick edge
    tagRst = "R2"; tagSus = "R10"; bitMode = 2;
    run(60);
    // R5/R8: repeat requests while busy are dropped
    tagRst = "R5"; tagRes = "R8";
    coldReq = 1; resumeReq = 1; stepCycle();
    run(9);
    coldReq = 1; resumeReq = 1; stepCycle();
    for (int i = 0; i < 60; i++) begin
      coldReq = 1; resumeReq = (i % 3 == 0); stepCycle();
    end
    run(80);
    // R9: both requests on one edge
    tagRst = "R9"; tagRes = "R9";
    coldReq = 1; resumeReq = 1; stepCycle();
    run(70);
    // R11/R12: long idle, then one change
    tagRst = "R3"; tagRes = "R6"; tagSus = "R12";
    bitMode = 0;
    run(100);
    bitClkIn = ~bitClkIn; stepCycle();
    tagSus = "R11";
    run(30);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 40) == 0) coldReq = 1;
      if (($urandom % 40) == 0) resumeReq = 1;
      if (($urandom % 150) == 0) begin bitMode = $urandom % 5; bitPhase = 0; end
      tagSus = (i % 2 == 0) ? "R10" : "R11";
      stepCycle();
    end
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule